// File: doc/BRIEF.md
# Sigma-Delta Sinc Decimator

This block turns the single-bit output of an external sigma-delta modulator into signed multi-bit samples. The modulator supplies its own bit clock. The block brings that clock and the data bit into the system clock domain and takes one data bit on each rising or each falling modulator-clock edge. Each bit drives a cascaded sinc decimation filter. Its order and decimation ratio D are chosen at run time. A second accumulator then adds I consecutive decimated values. The block subtracts a DC offset from the total, shifts it right arithmetically and clamps it to 24 signed bits. It presents the result sign-extended in a 32-bit word, together with a one-cycle strobe.

The configuration inputs are captured only while `enable` is low. Raising `enable` starts a clean run from cleared filter state. Settings whose sinc full-scale does not fit the accumulator are refused: the block raises an error flag and does not run.

Top module: `sdm_sinc_decim`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sample` is 0 and `cfg_err` is 0.
- R2: A data bit of 1 counts as +1 and a bit of 0 counts as -1. For `cfg_order` values 1 to 5 (order N), a constant input gives samples of ±D^N·I.
- R3: A `cfg_order` of 0 selects a fast-sinc mode, where each decimated value is the sum of the current and the previous second-order sinc outputs. A constant input gives ±2·D²·I.
- R4: Each output adds I successive decimated values. A bit pattern that repeats every D bits, with p ones and q zeros, gives (p−q)·D^(N−1)·I.
- R5: `out_valid` goes high for exactly one system cycle, once every D·I modulator sampling edges.
- R6: With `cfg_fall_edge` = 0 the data bit is taken at rising modulator-clock edges. With 1 it is taken at falling edges.
- R7: `cfg_offset`, a signed 32-bit value, is subtracted from the integrated total before the shift.
- R8: After the offset is subtracted, the total is shifted right arithmetically by `cfg_shift` bits.
- R9: The shifted value is clamped to [−8388608, 8388607]. It appears in bits 23:0 of `out_sample`, with bits 31:24 copying bit 23.
- R10: `cfg_err` goes high, and no sample is produced, when the sinc full-scale (D^N, or 2·D² for order 0) exceeds 2^31, when `cfg_order` > 5, when D < 2, or when I = 0.
- R11: Configuration inputs are captured only in cycles where `enable` is low. Changes made in the cycle `enable` rises, or while it is high, have no effect on output values, output rate or `cfg_err`.
- R12: Raising `enable` clears all filter state, and the decimated values produced during warm-up are dropped. As a result, every sample delivered for a steady input already equals the settled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; configuration is captured while low |
| mod_clk | input | 1 | Modulator bit clock (asynchronous) |
| mod_data | input | 1 | Modulator bitstream |
| cfg_order | input | 3 | 0 = fast sinc, 1..5 = sinc order |
| cfg_dec | input | 11 | Decimation ratio D |
| cfg_integ | input | 8 | Integration count I |
| cfg_offset | input | 32 | Signed DC offset subtracted from each total |
| cfg_shift | input | 5 | Arithmetic right shift after the offset |
| cfg_fall_edge | input | 1 | 0 = rising-edge sampling, 1 = falling-edge sampling |
| cfg_err | output | 1 | Captured configuration is invalid |
| out_valid | output | 1 | One-cycle sample strobe |
| out_sample | output | 32 | Sign-extended 24-bit sample |

## Verification
Two events can land in the same system cycle: the rising edge of `enable`, which ends configuration capture, and a change on the configuration inputs. The bench raises `enable` and writes a different order, ratio and count at the same falling clock edge. It then writes an invalid set while the block is running. It judges the result by the sample values, by the spacing of the strobes in modulator periods, and by `cfg_err` staying low. All three must follow the settings held before `enable` rose. The invalid set may show up on `cfg_err` only after `enable` drops again.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } smp_edge_e;

   localparam logic [63:0] SINC_FS_LIMIT = 64'h0000_0000_8000_0000;

   // full-scale magnitude of the sinc stage for a given order and ratio
   function automatic logic [63:0] sinc_fullscale(input logic [2:0] ord, input logic [63:0] dec);
      logic [63:0] p;
      p = 64'd1;
      for (int k = 0; k < 7; k++) begin
         if (k < int'(ord)) p = p * dec;
      end
      if (ord == 3'd0) p = 64'd2 * dec * dec;
      return p;
   endfunction

endpackage

// File: rtl/sdm_edge_sampler.sv
module sdm_edge_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic mclk_in,
   input  logic mdat_in,
   input  logic fall_sel,
   output logic smp_stb,
   output logic smp_bit
);
   import sdm_pkg::*;

   logic [SYNC_STAGES:0]   ck_sh;
   logic [SYNC_STAGES-1:0] dt_sh;
   logic                   ck_new, ck_old, edge_hit;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   assign ck_new   = ck_sh[SYNC_STAGES-1];
   assign ck_old   = ck_sh[SYNC_STAGES];
   assign edge_hit = (smp_edge_e'(fall_sel) == EDGE_FALL) ? (ck_old & ~ck_new)
                                                          : (ck_new & ~ck_old);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_sh   <= '0;
         dt_sh   <= '0;
         smp_stb <= 1'b0;
         smp_bit <= 1'b0;
      end else begin
         ck_sh   <= {ck_sh[SYNC_STAGES-1:0], mclk_in};
         dt_sh   <= {dt_sh[SYNC_STAGES-2:0], mdat_in};
         smp_stb <= run & edge_hit;
         smp_bit <= dt_sh[SYNC_STAGES-1];
      end
   end

   // R6: one sample per detected modulator edge, never two in a row
   a_r6_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);

endmodule

// File: rtl/sdm_sinc_core.sv
module sdm_sinc_core #(
   parameter int unsigned ACC_W   = 34,
   parameter int unsigned DEC_W   = 11,
   parameter int unsigned MAX_ORD = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    smp_stb,
   input  logic                    smp_bit,
   input  logic [2:0]              order,
   input  logic [DEC_W-1:0]        dec,
   output logic                    dec_stb,
   output logic signed [ACC_W-1:0] dec_val
);
   localparam int unsigned WARM_W = 4;

   if (MAX_ORD < 2 || MAX_ORD > 7) begin : g_bad_ord
      $error("MAX_ORD must lie in 2..7");
   end

   logic [2:0]              n_stg;
   logic [WARM_W-1:0]       warm_lim, warm_cnt;
   logic [DEC_W-1:0]        cnt;
   logic                    fire, warm_done;
   logic signed [ACC_W-1:0] step, prev2, sinc_now, fast_now;
   logic signed [ACC_W-1:0] integ [MAX_ORD];
   logic signed [ACC_W-1:0] dly   [MAX_ORD];
   logic signed [ACC_W-1:0] cin   [MAX_ORD+1];

   assign n_stg     = (order == 3'd0) ? 3'd2 :
                      (32'(order) > MAX_ORD) ? 3'(MAX_ORD) : order;
   assign warm_lim  = WARM_W'(n_stg) + WARM_W'(3) + ((order == 3'd0) ? WARM_W'(1) : WARM_W'(0));
   assign warm_done = (warm_cnt == warm_lim);
   assign step      = smp_bit ? ACC_W'(1) : '1;
   assign fire      = smp_stb && (cnt == dec - 1'b1);
   assign cin[0]    = integ[n_stg - 3'd1];
   assign sinc_now  = cin[n_stg];
   assign fast_now  = cin[2] + prev2;

   for (genvar s = 0; s < MAX_ORD; s++) begin : g_stage
      logic signed [ACC_W-1:0] feed;
      if (s == 0) begin : g_head
         assign feed = step;
      end else begin : g_tail
         assign feed = integ[s-1];
      end
      assign cin[s+1] = cin[s] - dly[s];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            integ[s] <= '0;
            dly[s]   <= '0;
         end else if (!run) begin
            integ[s] <= '0;
            dly[s]   <= '0;
         end else begin
            if (smp_stb) integ[s] <= integ[s] + feed;
            if (fire)    dly[s]   <= cin[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         warm_cnt <= '0;
         prev2    <= '0;
         dec_stb  <= 1'b0;
         dec_val  <= '0;
      end else if (!run) begin
         cnt      <= '0;
         warm_cnt <= '0;
         prev2    <= '0;
         dec_stb  <= 1'b0;
      end else begin
         dec_stb <= fire && warm_done;
         if (smp_stb) cnt <= (cnt == dec - 1'b1) ? '0 : cnt + 1'b1;
         if (fire) begin
            prev2   <= cin[2];
            dec_val <= (order == 3'd0) ? fast_now : sinc_now;
            if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
         end
      end
   end

   // R12: a stopped filter emits nothing
   a_r12_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !dec_stb);
   // R5: decimated values only follow a taken sample
   a_r5_dec_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stb |-> $past(smp_stb));

endmodule

// File: rtl/sdm_post.sv
module sdm_post #(
   parameter int unsigned ACC_W   = 34,
   parameter int unsigned INT_W   = 8,
   parameter int unsigned SHIFT_W = 5,
   parameter int unsigned OUT_W   = 24,
   parameter int unsigned WORD_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    dec_stb,
   input  logic signed [ACC_W-1:0] dec_val,
   input  logic [INT_W-1:0]        integ_n,
   input  logic [WORD_W-1:0]       offset,
   input  logic [SHIFT_W-1:0]      shift,
   output logic                    out_valid,
   output logic [WORD_W-1:0]       out_word
);
   localparam int unsigned SUM_W = ACC_W + INT_W + 1;
   localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;

   if (SUM_W <= WORD_W || OUT_W > WORD_W) begin : g_bad_width
      $error("post-stage widths inconsistent");
   end

   logic [INT_W-1:0]        icnt;
   logic signed [SUM_W-1:0] acc, total, corr, shifted;
   logic signed [OUT_W-1:0] clipped;
   logic                    last;

   assign total   = acc + SUM_W'(dec_val);
   assign last    = dec_stb && (icnt == integ_n - 1'b1);
   assign corr    = total - SUM_W'($signed(offset));
   assign shifted = corr >>> shift;

   always_comb begin
      if (shifted > SAT_HI)      clipped = SAT_HI[OUT_W-1:0];
      else if (shifted < SAT_LO) clipped = SAT_LO[OUT_W-1:0];
      else                       clipped = shifted[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc       <= '0;
         icnt      <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
      end else if (!run) begin
         acc       <= '0;
         icnt      <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= last;
         if (last) out_word <= {{(WORD_W-OUT_W){clipped[OUT_W-1]}}, clipped};
         if (dec_stb) begin
            if (last) begin
               acc  <= '0;
               icnt <= '0;
            end else begin
               acc  <= total;
               icnt <= icnt + 1'b1;
            end
         end
      end
   end

   // R5: the strobe lasts one cycle
   a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R9: the delivered word is a sign-extended 24-bit value
   a_r9_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[WORD_W-1:OUT_W-1] == '0 || out_word[WORD_W-1:OUT_W-1] == '1));

endmodule

// File: rtl/sdm_sinc_decim.sv
module sdm_sinc_decim #(
   parameter int unsigned DEC_W       = 11,
   parameter int unsigned INT_W       = 8,
   parameter int unsigned ACC_W       = 34,
   parameter int unsigned SHIFT_W     = 5,
   parameter int unsigned OUT_W       = 24,
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               mod_clk,
   input  logic               mod_data,
   input  logic [2:0]         cfg_order,
   input  logic [DEC_W-1:0]   cfg_dec,
   input  logic [INT_W-1:0]   cfg_integ,
   input  logic [WORD_W-1:0]  cfg_offset,
   input  logic [SHIFT_W-1:0] cfg_shift,
   input  logic               cfg_fall_edge,
   output logic               cfg_err,
   output logic               out_valid,
   output logic [WORD_W-1:0]  out_sample
);
   import sdm_pkg::*;

   localparam int unsigned MAX_ORD = 5;

   if (ACC_W < 34 || DEC_W > 12 || WORD_W != 32) begin : g_bad_top
      $error("accumulator must hold +/-2^31; ratio width at most 12; word is 32 bits");
   end

   logic [2:0]              order_q;
   logic [DEC_W-1:0]        dec_q;
   logic [INT_W-1:0]        integ_q;
   logic [WORD_W-1:0]       offset_q;
   logic [SHIFT_W-1:0]      shift_q;
   logic                    fall_q, bad_now, run;
   logic [63:0]             fs_now;
   logic                    smp_stb, smp_bit, dec_stb;
   logic signed [ACC_W-1:0] dec_val;

   assign fs_now  = sinc_fullscale(order_q, 64'(dec_q));
   assign bad_now = (order_q > 3'd5) || (dec_q < DEC_W'(2)) || (integ_q == '0) ||
                    (fs_now > SINC_FS_LIMIT);
   assign run     = enable & ~cfg_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         order_q  <= 3'd1;
         dec_q    <= DEC_W'(2);
         integ_q  <= INT_W'(1);
         offset_q <= '0;
         shift_q  <= '0;
         fall_q   <= 1'b0;
         cfg_err  <= 1'b0;
      end else begin
         cfg_err <= bad_now;
         if (!enable) begin
            order_q  <= cfg_order;
            dec_q    <= cfg_dec;
            integ_q  <= cfg_integ;
            offset_q <= cfg_offset;
            shift_q  <= cfg_shift;
            fall_q   <= cfg_fall_edge;
         end
      end
   end

   sdm_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .run(run), .mclk_in(mod_clk), .mdat_in(mod_data),
      .fall_sel(fall_q), .smp_stb(smp_stb), .smp_bit(smp_bit));

   sdm_sinc_core #(.ACC_W(ACC_W), .DEC_W(DEC_W), .MAX_ORD(MAX_ORD)) u_sinc (
      .clk(clk), .rst_n(rst_n), .run(run), .smp_stb(smp_stb), .smp_bit(smp_bit),
      .order(order_q), .dec(dec_q), .dec_stb(dec_stb), .dec_val(dec_val));

   sdm_post #(.ACC_W(ACC_W), .INT_W(INT_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W), .WORD_W(WORD_W)) u_post (
      .clk(clk), .rst_n(rst_n), .run(run), .dec_stb(dec_stb), .dec_val(dec_val),
      .integ_n(integ_q), .offset(offset_q), .shift(shift_q),
      .out_valid(out_valid), .out_word(out_sample));

   // R10: a refused configuration never yields samples
   a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !out_valid);
   // R11: captured settings hold while running
   a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enable) |-> ($stable(order_q) && $stable(dec_q) && $stable(integ_q) &&
                          $stable(offset_q) && $stable(shift_q) && $stable(fall_q)));

endmodule

// File: tb/sdm_sinc_decim_bench.sv
module sdm_sinc_decim_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        mod_clk = 1'b0;
   logic        mod_data = 1'b0;
   logic [2:0]  cfg_order = 3'd1;
   logic [10:0] cfg_dec = 11'd8;
   logic [7:0]  cfg_integ = 8'd1;
   logic [31:0] cfg_offset = '0;
   logic [4:0]  cfg_shift = '0;
   logic        cfg_fall_edge = 1'b0;
   logic        cfg_err, out_valid;
   logic [31:0] out_sample;

   int n_chk = 0;
   int n_fail = 0;
   int pat_len = 1;
   int pat_ones = 1;
   bit split = 1'b0;
   int bit_idx = 0;
   int mc_cnt = 0;
   int cap_n = 0;
   int cap_v [64];
   int cap_mc [64];

   sdm_sinc_decim u_sdm_sinc_decim (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mod_clk(mod_clk), .mod_data(mod_data),
      .cfg_order(cfg_order), .cfg_dec(cfg_dec), .cfg_integ(cfg_integ), .cfg_offset(cfg_offset),
      .cfg_shift(cfg_shift), .cfg_fall_edge(cfg_fall_edge), .cfg_err(cfg_err),
      .out_valid(out_valid), .out_sample(out_sample));

   always #4 clk = ~clk;

   // modulator model: one bit per 64 ns period, changes at system falling edges
   always begin
      mod_clk = 1'b1;
      mc_cnt++;
      #16;
      if (split) mod_data = 1'b0;
      #16;
      mod_clk = 1'b0;
      #16;
      bit_idx++;
      mod_data = split ? 1'b1 : ((bit_idx % pat_len) < pat_ones);
      #16;
   end

   always @(negedge clk) begin
      if (out_valid && cap_n < 64) begin
         cap_v[cap_n]  = int'(out_sample);
         cap_mc[cap_n] = mc_cnt;
         cap_n++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int ord, input int dec, input int itg, input int off,
                          input int sh, input bit fall);
      cfg_order = 3'(ord);
      cfg_dec = 11'(dec);
      cfg_integ = 8'(itg);
      cfg_offset = 32'(off);
      cfg_shift = 5'(sh);
      cfg_fall_edge = fall;
   endtask

   task automatic wait_caps(input int nexp, input int dec, input int itg);
      int limit;
      limit = (16 + nexp) * dec * itg * 8 + 400;
      for (int c = 0; c < limit && cap_n < nexp; c++) @(negedge clk);
   endtask

   task automatic judge(input string req, input int nexp, input int expv, input int gap);
      chk({req, " sample count"}, cap_n, nexp);
      for (int k = 0; k < cap_n; k++) begin
         if (k == 0) chk({req, " R12 first sample settled"}, cap_v[k], expv);
         else        chk(req, cap_v[k], expv);
         if (k > 0)  chk({req, " R5 strobe spacing"}, cap_mc[k] - cap_mc[k-1], gap);
      end
   endtask

   task automatic run_case(input string req, input int ord, input int dec, input int itg,
                           input int off, input int sh, input bit fall, input int plen,
                           input int pones, input bit spl, input int nexp, input int expv);
      @(negedge clk);
      enable = 1'b0;
      set_cfg(ord, dec, itg, off, sh, fall);
      pat_len = plen;
      pat_ones = pones;
      split = spl;
      repeat (24) @(negedge clk);
      cap_n = 0;
      enable = 1'b1;
      wait_caps(nexp, dec, itg);
      enable = 1'b0;
      judge(req, nexp, expv, dec * itg);
   endtask

   task automatic bad_case(input string req, input int ord, input int dec, input int itg, input int exp_err);
      @(negedge clk);
      enable = 1'b0;
      set_cfg(ord, dec, itg, 0, 0, 1'b0);
      pat_len = 1;
      pat_ones = 1;
      split = 1'b0;
      repeat (4) @(negedge clk);
      chk({req, " cfg_err"}, int'(cfg_err), exp_err);
      if (exp_err == 1) begin
         cap_n = 0;
         enable = 1'b1;
         repeat (3000) @(negedge clk);
         enable = 1'b0;
         chk({req, " no samples while refused"}, cap_n, 0);
      end
   endtask

   task automatic t_reset;
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 out_sample", int'(out_sample), 0);
      chk("R1 cfg_err", int'(cfg_err), 0);
   endtask

   task automatic t_sinc_orders;
      run_case("R2 order1 ones", 1, 8, 1, 0, 0, 1'b0, 1, 1, 1'b0, 4, 8);
      run_case("R2 order1 zeros", 1, 8, 1, 0, 0, 1'b0, 1, 0, 1'b0, 4, -8);
      run_case("R2 order2 zeros", 2, 8, 1, 0, 0, 1'b0, 1, 0, 1'b0, 3, -64);
      run_case("R2 order5 ones", 5, 16, 4, 0, 0, 1'b0, 1, 1, 1'b0, 3, 4194304);
   endtask

   task automatic t_fast_sinc;
      run_case("R3 fast zeros", 0, 8, 1, 0, 0, 1'b0, 1, 0, 1'b0, 3, -128);
      run_case("R3 fast ones", 0, 16, 2, 0, 0, 1'b0, 1, 1, 1'b0, 3, 1024);
   endtask

   task automatic t_integration;
      run_case("R4 order3 6of8", 3, 8, 2, 0, 0, 1'b0, 8, 6, 1'b0, 3, 512);
      run_case("R4 order2 alternating", 2, 4, 3, 0, 0, 1'b0, 2, 1, 1'b0, 3, 0);
   endtask

   task automatic t_offset_shift;
      run_case("R7 offset +5", 1, 16, 1, 5, 0, 1'b0, 1, 1, 1'b0, 3, 11);
      run_case("R7 offset -100", 1, 16, 1, -100, 0, 1'b0, 1, 1, 1'b0, 3, 116);
      run_case("R8 shift 3", 3, 8, 1, 0, 3, 1'b0, 1, 1, 1'b0, 3, 64);
      run_case("R8 shift 4 negative", 3, 8, 1, 0, 4, 1'b0, 1, 0, 1'b0, 3, -32);
      run_case("R7 R8 offset before shift", 1, 16, 1, 4, 2, 1'b0, 1, 1, 1'b0, 3, 3);
   endtask

   task automatic t_saturate;
      run_case("R9 clamp high", 4, 64, 1, 0, 0, 1'b0, 1, 1, 1'b0, 3, 8388607);
      run_case("R9 clamp low", 4, 64, 1, 0, 0, 1'b0, 1, 0, 1'b0, 3, -8388608);
      run_case("R9 shifted into range", 4, 64, 1, 0, 2, 1'b0, 1, 1, 1'b0, 3, 4194304);
   endtask

   task automatic t_edges;
      run_case("R6 rising edge", 1, 8, 1, 0, 0, 1'b0, 1, 1, 1'b1, 3, 8);
      run_case("R6 falling edge", 1, 8, 1, 0, 0, 1'b1, 1, 1, 1'b1, 3, -8);
   endtask

   task automatic t_invalid;
      bad_case("R10 order5 D128", 5, 128, 1, 1);
      bad_case("R10 order4 D256", 4, 256, 1, 1);
      bad_case("R10 order4 D128 accepted", 4, 128, 1, 0);
      bad_case("R10 order6", 6, 8, 1, 1);
      bad_case("R10 ratio 1", 1, 1, 1, 1);
      bad_case("R10 count 0", 1, 8, 0, 1);
      bad_case("R10 recover", 1, 8, 1, 0);
   endtask

   task automatic t_cfg_hold;
      @(negedge clk);
      enable = 1'b0;
      set_cfg(1, 8, 1, 0, 0, 1'b0);
      pat_len = 1;
      pat_ones = 1;
      split = 1'b0;
      repeat (24) @(negedge clk);
      cap_n = 0;
      enable = 1'b1;
      set_cfg(2, 16, 3, 7, 1, 1'b1);      // same cycle as enable rises
      wait_caps(2, 8, 1);
      set_cfg(5, 128, 1, 0, 0, 1'b0);     // invalid set while running
      repeat (8) @(negedge clk);
      chk("R11 cfg_err while running", int'(cfg_err), 0);
      wait_caps(4, 8, 1);
      enable = 1'b0;
      judge("R11 settings held", 4, 8, 8);
      repeat (4) @(negedge clk);
      chk("R11 capture after disable", int'(cfg_err), 1);
      set_cfg(1, 8, 1, 0, 0, 1'b0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(8 * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_sinc_orders();
      t_fast_sinc();
      t_integration();
      t_offset_shift();
      t_saturate();
      t_edges();
      t_invalid();
      t_cfg_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule